// File: doc/BRIEF.md
# Abstract Register-Access Program Builder

This block turns a register-access abstract command from a debugger into the two instruction words that a halted hart fetches just ahead of the debugger-owned program buffer. The first word carries the register transfer, synthesized as a load or store between a general-purpose register and the first data word. That data word sits at a small address relative to zero, so the access needs only a 12-bit immediate and rs1 fixed to zero. The second word either falls through into the program buffer or stops the hart at once with an ebreak.

A command is captured on a single-cycle launch strobe. The built words stay in registers until the next launch. The hart fetches them through a word-aligned read port decoded against the debug module's memory window. The two built words and the program buffer form one contiguous region that ends right below the first data word. A command the block cannot carry out produces a "not supported" error code and no access.

Top module: `abstract_prog_builder`

## Requirements
- R1: After reset the access word is nop (0x00000013), the continuation word is ebreak (0x00100073) and cmderr is 0.
- R2: A supported launch with transfer=1 and write=1 makes the access word a load into x[regno[4:0]] from 0x400(x0). The load is {imm=0x400, rs1=0, funct3, rd, opcode}.
- R3: A supported launch with transfer=1 and write=0 makes the access word a store of x[regno[4:0]] to 0x400(x0). The store is {imm[11:5]=0100000, rs2, rs1=0, funct3, imm[4:0]=0, opcode 0100011}.
- R4: The size code picks the access form. Size 2 gives funct3 010 (lw/sw) and size 3 gives funct3 011 (ld/sd). Size 4 gives lq (opcode 0001111, funct3 010) or sq (opcode 0100011, funct3 100). Loads in sizes 2 and 3 use opcode 0000011.
- R5: A launch with transfer=0 makes the access word nop and cmderr 0, whatever regno and size hold.
- R6: With postexec=1 on a launch that reports no error, the continuation word is nop, so fetch runs on into the program buffer. With postexec=0 it is ebreak.
- R7: A launch with transfer=1 is unsupported in two cases: regno lies outside 0x1000..0x101F, or the size is 0, 1 or above the MAX_SIZE parameter (default 4). An unsupported launch sets cmderr to 2, makes the access word nop and makes the continuation word ebreak.
- R8: The access word is read at byte address DATA0_ADDR-4*(PB_WORDS+2) and the continuation word at the next word; with defaults these are 0x3F0 and 0x3F4. rd_hit is 1 only for these two aligned addresses. Every other address gives rd_hit=0 and rd_data=0.
- R9: The words and cmderr change only on a cycle with cmd_valid=1. Command inputs that change without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Launch strobe; the command fields are captured in this cycle |
| cmd_regno | input | 16 | Register number of the command |
| cmd_transfer | input | 1 | Perform the register transfer |
| cmd_write | input | 1 | 1: debugger writes the GPR (load); 0: reads it (store) |
| cmd_size | input | 3 | Access size code (2=32, 3=64, 4=128 bit) |
| cmd_postexec | input | 1 | Continue into the program buffer after the access |
| rd_addr | input | 12 | Hart fetch byte address within the debug window |
| rd_hit | output | 1 | Address selects one of the built words |
| rd_data | output | 32 | Instruction word returned to the hart |
| cmderr | output | 3 | Result of the last launch (0 ok, 2 not supported) |

## Verification
The bench sweeps regno across the edges of the GPR range (0x0FFF, 0x1000, 0x101F, 0x1020) and far outside it, under every size code, transfer, write and postexec value. It computes each instruction word from its fields. A builder that swapped the load and store forms, mixed up rd and rs2, picked the wrong funct3 or opcode for a size, or accepted regno 0x1020 would return a wrong word or a wrong cmderr. Transfer=0 with a bad regno or size checks that validation is skipped when no access is made. Unsupported commands with postexec=1 check that the program buffer is never entered after an error. A full sweep of the address window catches an off-by-one base or a decode that ignores misalignment. Field changes without the strobe catch a design that is transparent to its inputs.

// File: rtl/absprog_pkg.sv
`timescale 1ns/1ps
package absprog_pkg;

  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

  localparam logic [6:0] OPC_LOAD     = 7'b0000011;
  localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
  localparam logic [6:0] OPC_STORE    = 7'b0100011;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_NOT_SUPP = 3'd2;

  localparam logic [15:0] GPR_REGNO_BASE = 16'h1000;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [4:0] gpr;
    logic [2:0] size;
    logic       stop;
    logic [2:0] err;
  } acc_plan_t;

endpackage

// File: rtl/absprog_decode.sv
`timescale 1ns/1ps
module absprog_decode
  import absprog_pkg::*;
#(
  parameter int MAX_SIZE = 4
) (
  input  logic [15:0] regno,
  input  logic        transfer,
  input  logic        write,
  input  logic [2:0]  size,
  input  logic        postexec,
  output acc_plan_t   plan
);

  localparam logic [2:0] MAX_SZ = 3'(MAX_SIZE);
  localparam logic [2:0] MIN_SZ = 3'd2;

  logic regno_ok;
  logic size_ok;
  logic reject;

  always_comb begin
    regno_ok = (regno[15:5] == GPR_REGNO_BASE[15:5]);
    size_ok  = (size >= MIN_SZ) && (size <= MAX_SZ);
    reject   = transfer && !(regno_ok && size_ok);

    plan.gpr  = regno[4:0];
    plan.size = size;
    plan.err  = reject ? ERR_NOT_SUPP : ERR_NONE;
    plan.stop = reject || !postexec;
    if (!transfer || reject) begin
      plan.kind = ACC_NONE;
    end else if (write) begin
      plan.kind = ACC_LOAD;
    end else begin
      plan.kind = ACC_STORE;
    end
  end

  // R7: a rejected transfer never yields an access and always stops
  always_comb begin
    if (reject) begin
      a_reject_no_access_r7: assert (plan.kind == ACC_NONE && plan.stop);
    end
  end

endmodule

// File: rtl/absprog_encode.sv
`timescale 1ns/1ps
module absprog_encode
  import absprog_pkg::*;
(
  input  acc_plan_t   plan,
  output logic [31:0] acc_word,
  output logic [31:0] cont_word
);

  localparam logic [11:0] DATA_IMM = 12'h400;

  logic [2:0] ld_f3;
  logic [2:0] st_f3;
  logic [6:0] ld_opc;

  always_comb begin
    ld_f3  = 3'b010;
    st_f3  = 3'b010;
    ld_opc = OPC_LOAD;
    case (plan.size)
      3'd3: begin
        ld_f3 = 3'b011;
        st_f3 = 3'b011;
      end
      3'd4: begin
        ld_f3  = 3'b010;
        st_f3  = 3'b100;
        ld_opc = OPC_MISC_MEM;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (plan.kind)
      ACC_LOAD:  acc_word = {DATA_IMM, 5'd0, ld_f3, plan.gpr, ld_opc};
      ACC_STORE: acc_word = {DATA_IMM[11:5], plan.gpr, 5'd0, st_f3,
                             DATA_IMM[4:0], OPC_STORE};
      default:   acc_word = INSN_NOP;
    endcase
    cont_word = plan.stop ? INSN_EBREAK : INSN_NOP;
  end

  // R2/R3: every generated access is zero-relative (rs1 = x0)
  always_comb begin
    if (plan.kind != ACC_NONE) begin
      a_rs1_zero_r2: assert (acc_word[19:15] == 5'd0);
    end
  end

endmodule

// File: rtl/absprog_window.sv
`timescale 1ns/1ps
module absprog_window #(
  parameter int DATA0_ADDR = 'h400,
  parameter int PB_WORDS   = 2
) (
  input  logic [11:0] addr,
  input  logic [31:0] acc_word,
  input  logic [31:0] cont_word,
  output logic        hit,
  output logic [31:0] data
);

  localparam int         ABS_BASE = DATA0_ADDR - 4 * (PB_WORDS + 2);
  localparam logic [9:0] ACC_IDX  = 10'(ABS_BASE / 4);
  localparam logic [9:0] CONT_IDX = 10'(ABS_BASE / 4 + 1);

  logic aligned;
  logic sel_acc;
  logic sel_cont;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    sel_acc  = aligned && (addr[11:2] == ACC_IDX);
    sel_cont = aligned && (addr[11:2] == CONT_IDX);
    hit      = sel_acc || sel_cont;
    data     = sel_acc  ? acc_word  :
               sel_cont ? cont_word : 32'd0;
  end

  // R8: at most one built word is selected for any address
  always_comb begin
    a_one_select_r8: assert ($onehot0({sel_acc, sel_cont}));
  end

endmodule

// File: rtl/abstract_prog_builder.sv
`timescale 1ns/1ps
module abstract_prog_builder
  import absprog_pkg::*;
#(
  parameter int MAX_SIZE   = 4,
  parameter int DATA0_ADDR = 'h400,
  parameter int PB_WORDS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_regno,
  input  logic        cmd_transfer,
  input  logic        cmd_write,
  input  logic [2:0]  cmd_size,
  input  logic        cmd_postexec,
  input  logic [11:0] rd_addr,
  output logic        rd_hit,
  output logic [31:0] rd_data,
  output logic [2:0]  cmderr
);

  acc_plan_t   plan;
  logic [31:0] new_acc;
  logic [31:0] new_cont;

  logic [31:0] acc_q,  acc_d;
  logic [31:0] cont_q, cont_d;
  logic [2:0]  err_q,  err_d;

  absprog_decode #(.MAX_SIZE(MAX_SIZE)) u_decode (
    .regno    (cmd_regno),
    .transfer (cmd_transfer),
    .write    (cmd_write),
    .size     (cmd_size),
    .postexec (cmd_postexec),
    .plan     (plan)
  );

  absprog_encode u_encode (
    .plan      (plan),
    .acc_word  (new_acc),
    .cont_word (new_cont)
  );

  always_comb begin
    acc_d  = acc_q;
    cont_d = cont_q;
    err_d  = err_q;
    if (cmd_valid) begin
      acc_d  = new_acc;
      cont_d = new_cont;
      err_d  = plan.err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= INSN_NOP;
      cont_q <= INSN_EBREAK;
      err_q  <= ERR_NONE;
    end else begin
      acc_q  <= acc_d;
      cont_q <= cont_d;
      err_q  <= err_d;
    end
  end

  absprog_window #(
    .DATA0_ADDR (DATA0_ADDR),
    .PB_WORDS   (PB_WORDS)
  ) u_window (
    .addr      (rd_addr),
    .acc_word  (acc_q),
    .cont_word (cont_q),
    .hit       (rd_hit),
    .data      (rd_data)
  );

  assign cmderr = err_q;

  p_idle_is_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_transfer) |=> (acc_q == INSN_NOP && err_q == ERR_NONE));

  p_stop_without_postexec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_postexec) |=> (cont_q == INSN_EBREAK));

  p_error_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == ERR_NOT_SUPP) |-> (acc_q == INSN_NOP && cont_q == INSN_EBREAK));

  p_hold_without_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(acc_q) && $stable(cont_q) && $stable(err_q)));

endmodule

// File: tb/test_abstract_prog_builder.sv
`timescale 1ns/1ps
module test_abstract_prog_builder;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_regno;
  logic        cmd_transfer;
  logic        cmd_write;
  logic [2:0]  cmd_size;
  logic        cmd_postexec;
  logic [11:0] rd_addr;
  logic        rd_hit;
  logic [31:0] rd_data;
  logic [2:0]  cmderr;

  int n_checks;
  int n_errors;
  bit done;

  localparam logic [31:0] NOP    = 32'h00000013;
  localparam logic [31:0] EBREAK = 32'h00100073;
  localparam logic [11:0] A_ACC  = 12'h3F0;
  localparam logic [11:0] A_CONT = 12'h3F4;

  abstract_prog_builder i_abstract_prog_builder (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_regno    (cmd_regno),
    .cmd_transfer (cmd_transfer),
    .cmd_write    (cmd_write),
    .cmd_size     (cmd_size),
    .cmd_postexec (cmd_postexec),
    .rd_addr      (rd_addr),
    .rd_hit       (rd_hit),
    .rd_data      (rd_data),
    .cmderr       (cmderr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit supported(input int regno, input int size);
    return (regno >= 'h1000) && (regno <= 'h101F) && (size >= 2) && (size <= 4);
  endfunction

  function automatic logic [31:0] exp_acc(input int regno, input bit tr, input bit wr, input int size);
    int gpr;
    int f3;
    int opc;
    if (!tr || !supported(regno, size)) return NOP;
    gpr = regno % 32;
    if (wr) begin
      f3  = (size == 3) ? 3 : 2;
      opc = (size == 4) ? 'h0F : 'h03;
      return 32'('h40000000 + f3 * 4096 + gpr * 128 + opc);
    end
    f3 = (size == 4) ? 4 : size;
    return 32'('h40000000 + gpr * (1 << 20) + f3 * 4096 + 'h23);
  endfunction

  task automatic read_words(output logic [31:0] a, output logic [31:0] c);
    rd_addr = A_ACC;
    #1 a = rd_data;
    rd_addr = A_CONT;
    #1 c = rd_data;
  endtask

  task automatic launch(input int regno, input bit tr, input bit wr, input int size, input bit pe);
    @(negedge clk);
    cmd_valid    = 1'b1;
    cmd_regno    = 16'(regno);
    cmd_transfer = tr;
    cmd_write    = wr;
    cmd_size     = 3'(size);
    cmd_postexec = pe;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [31:0] c;
    int regs[$];
    n_checks = 0;
    n_errors = 0;
    done = 0;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_regno = 16'h0;
    cmd_transfer = 1'b0;
    cmd_write = 1'b0;
    cmd_size = 3'd0;
    cmd_postexec = 1'b0;
    rd_addr = 12'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_words(a, c);
    check32("R1 access word", a, NOP);
    check32("R1 continuation word", c, EBREAK);
    check32("R1 cmderr", 32'(cmderr), 0);

    regs.push_back('h0FFF);
    regs.push_back('h1020);
    regs.push_back('h0005);
    regs.push_back('hC000);
    regs.push_back('h2010);
    for (int g = 0; g < 32; g++) regs.push_back('h1000 + g);

    // R2 R3 R4 R5 R6 R7 sweep
    foreach (regs[i]) begin
      for (int sz = 0; sz < 8; sz++) begin
        for (int m = 0; m < 8; m++) begin
          bit tr;
          bit wr;
          bit pe;
          bit bad;
          tr = m[0];
          wr = m[1];
          pe = m[2];
          bad = tr && !supported(regs[i], sz);
          launch(regs[i], tr, wr, sz, pe);
          read_words(a, c);
          if (!tr) check32("R5 nop access", a, NOP);
          else if (bad) check32("R7 rejected access", a, NOP);
          else if (wr) check32("R2/R4 load word", a, exp_acc(regs[i], tr, wr, sz));
          else check32("R3/R4 store word", a, exp_acc(regs[i], tr, wr, sz));
          check32(bad ? "R7 continuation" : "R6 continuation", c, (pe && !bad) ? NOP : EBREAK);
          check32(bad ? "R7 cmderr" : "R5 cmderr", 32'(cmderr), bad ? 2 : 0);
        end
      end
    end

    // R9 inputs change without the strobe
    launch('h1007, 1, 0, 3, 1);
    @(negedge clk);
    cmd_regno = 16'h1013;
    cmd_write = 1'b1;
    cmd_size = 3'd7;
    cmd_postexec = 1'b0;
    repeat (2) @(negedge clk);
    read_words(a, c);
    check32("R9 access held", a, exp_acc('h1007, 1, 0, 3));
    check32("R9 continuation held", c, NOP);
    check32("R9 cmderr held", 32'(cmderr), 0);

    // R8 window decode over all addresses
    launch('h1009, 1, 1, 2, 1);
    for (int ad = 0; ad < 4096; ad++) begin
      logic [31:0] ed;
      bit eh;
      rd_addr = 12'(ad);
      #0.01;
      eh = (ad == 'h3F0) || (ad == 'h3F4);
      ed = (ad == 'h3F0) ? exp_acc('h1009, 1, 1, 2) : (ad == 'h3F4) ? NOP : 32'd0;
      check32("R8 rd_hit", 32'(rd_hit), 32'(eh));
      check32("R8 rd_data", rd_data, ed);
    end

    // R1 reset again after activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_words(a, c);
    check32("R1 access after reset", a, NOP);
    check32("R1 continuation after reset", c, EBREAK);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule